// File: doc/BRIEF.md
# K-line Transceiver Control

This block holds the digital side of a single-wire K-line bus port. The transmit input selects an open-drain pull-down: a low transmit level asks for the bus to be pulled low, and a high level releases it. A comparator input reports whether the bus sits below 0.45 times the supply. That level is synchronised and returned on the receive output, so the host can read incoming data and check its own transmitted bits against the bus.

A short-circuit timer protects the pull-down. The timer runs while the driver is enabled but the bus stays high. It stops the driver after a programmable number of clock cycles, 20 µs in the target system. The block then raises a sticky short flag. The driver stays off until the host produces a fresh falling edge on the transmit input. A global shutdown input, fed by thermal or overvoltage detection, forces the driver off at once whatever the transmit level. The block must support bus rates up to 60 kbit/s, which is far slower than the clock.

Top module: `kline_xcvr`

## Requirements
- R1: `tx_i` passes through a `SYNC_STAGES` flop synchroniser. `drv_en_o` is 1 while the synchronised transmit level is 0 and the driver is armed, and 0 while it is 1. With two stages a change on `tx_i` reaches `drv_en_o` after the second rising clock edge.
- R2: `rx_o` is the inverse of `line_low_i` (1 = bus below threshold) after a `SYNC_STAGES` flop synchroniser, whatever the driver state. A high bus reads as `rx_o` = 1.
- R3: If `drv_en_o` stays 1 while the synchronised bus level stays high for `TIMEOUT_CYCLES` consecutive cycles, `drv_en_o` goes to 0 after the next edge. The driver is therefore on for exactly `TIMEOUT_CYCLES` cycles against a stuck-high bus.
- R4: Any cycle in which the synchronised bus level is low, or the driver is off, clears the short timer, so a brief dip of the bus restarts the full timeout.
- R5: After a timeout the driver stays off while the transmit level is held low or is high. It is re-armed only by a high-to-low transition of the synchronised transmit level, and drives again one cycle after that transition is seen.
- R6: `short_flag_o` goes to 1 on the edge where the timeout fires. It stays set until the re-arming falling edge, which clears it.
- R7: `shutdown_i` = 1 forces `drv_en_o` to 0 in the same cycle. The short timer does not advance while shutdown holds the driver off, so a long shutdown never sets `short_flag_o`. Releasing shutdown restores the driver if still armed.
- R8: While `rst_n` is low, `drv_en_o` = 0, `rx_o` = 1, `short_flag_o` = 0, and the driver is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_i | input | 1 | Transmit data, 0 = pull bus low |
| line_low_i | input | 1 | Bus comparator, 1 = bus below 0.45 x supply |
| shutdown_i | input | 1 | Thermal/overvoltage kill, 1 = driver off |
| drv_en_o | output | 1 | Open-drain pull-down enable |
| rx_o | output | 1 | Received bus level, 1 = bus high |
| short_flag_o | output | 1 | Sticky bus-short status |

## Verification
The first pattern is a toggling transmit stream on a healthy bus that follows the driver. It separates synchroniser latency and receive polarity from any timeout action, because the timer must never fire there. The second holds transmit low against a bus that stays high, and counts the driven cycles to pin the timeout length. It then shows that a held-low or high level cannot re-arm the driver and that only a new falling edge can. A one-cycle dip of the bus during that pattern separates a restarting timer from one that only pauses or ignores the dip. A shutdown held well past the timeout separates a timer gated by the real driver state from one gated only by the transmit level.

// File: rtl/kline_pkg.sv
package kline_pkg;

  // Bits needed to hold a count that runs 0 .. limit-1.
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // True on the last cycle of a window of `limit` cycles.
  function automatic logic at_limit(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

  // Pull-down request: transmit low, armed, not in shutdown.
  function automatic logic drive_ok(input logic tx_lvl, input logic armed,
                                    input logic kill);
    return ~tx_lvl & armed & ~kill;
  endfunction

endpackage

// File: rtl/kline_sync.sv
module kline_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/kline_short_timer.sv
module kline_short_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_en_i,
  input  logic line_low_i,
  output logic timeout_o
);

  localparam int unsigned CNT_W = kline_pkg::cnt_bits(TIMEOUT_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             stuck;

  // Driver on but bus still above threshold.
  assign stuck     = drv_en_i & ~line_low_i;
  assign timeout_o = stuck & kline_pkg::at_limit(32'(cnt_q), TIMEOUT_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!stuck || timeout_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(stuck));

  // R4
  dip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en_i && line_low_i) |=> (cnt_q == '0));

endmodule

// File: rtl/kline_drv_ctrl.sv
module kline_drv_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_s_i,
  input  logic shutdown_i,
  input  logic timeout_i,
  output logic drv_en_o,
  output logic short_flag_o
);

  logic tx_q;
  logic armed_q;
  logic tx_fall;

  assign tx_fall  = tx_q & ~tx_s_i;
  assign drv_en_o = kline_pkg::drive_ok(tx_s_i, armed_q, shutdown_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q         <= 1'b1;
      armed_q      <= 1'b1;
      short_flag_o <= 1'b0;
    end else begin
      tx_q <= tx_s_i;
      if (tx_fall) begin
        armed_q      <= 1'b1;
        short_flag_o <= 1'b0;
      end else if (timeout_i) begin
        armed_q      <= 1'b0;
        short_flag_o <= 1'b1;
      end
    end
  end

  // R3
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i && !tx_fall) |=> !drv_en_o);

  // R5
  rearm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(tx_fall));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_flag_o) |-> $past(timeout_i));

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_flag_o) |-> $past(tx_fall));

endmodule

// File: rtl/kline_xcvr.sv
module kline_xcvr #(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned TIMEOUT_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_i,
  input  logic line_low_i,
  input  logic shutdown_i,
  output logic drv_en_o,
  output logic rx_o,
  output logic short_flag_o
);

  logic tx_s;
  logic line_low_s;
  logic timeout;

  kline_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_tx_sync (
    .clk(clk), .rst_n(rst_n), .d_i(tx_i), .q_o(tx_s)
  );

  kline_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_low_i), .q_o(line_low_s)
  );

  kline_short_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .drv_en_i(drv_en_o),
    .line_low_i(line_low_s), .timeout_o(timeout)
  );

  kline_drv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_s_i(tx_s), .shutdown_i(shutdown_i),
    .timeout_i(timeout), .drv_en_o(drv_en_o), .short_flag_o(short_flag_o)
  );

  assign rx_o = ~line_low_s;

  // R7
  kill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_i && !short_flag_o) |=> !$rose(short_flag_o));

endmodule

// File: tb/kline_xcvr_bench.sv
module kline_xcvr_bench;

  localparam int unsigned SYNC  = 2;
  localparam int unsigned LIMIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_i = 1'b1;
  logic line_low_i = 1'b0;
  logic shutdown_i = 1'b0;
  logic drv_en_o, rx_o, short_flag_o;

  bit bus_short = 1'b0;
  bit ext_low   = 1'b0;
  bit done      = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  kline_xcvr #(.SYNC_STAGES(SYNC), .TIMEOUT_CYCLES(LIMIT)) u_kline_xcvr (
    .clk(clk), .rst_n(rst_n), .tx_i(tx_i), .line_low_i(line_low_i),
    .shutdown_i(shutdown_i), .drv_en_o(drv_en_o), .rx_o(rx_o),
    .short_flag_o(short_flag_o)
  );

  // Bus: pulled low by the driver unless shorted, or by another node.
  always @(negedge clk) line_low_i <= (drv_en_o && !bus_short) || ext_low;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference model: behavioural, delays held in queues.
  bit tx_pipe[$];
  bit ll_pipe[$];
  bit m_txs, m_txprev, m_lls, m_armed, m_flag;
  int m_stuck_cycles;

  always @(posedge clk) begin
    bit drv_now, stuck, fire, fall;
    if (!rst_n) begin
      tx_pipe = {};
      ll_pipe = {};
      for (int i = 0; i < SYNC; i++) begin
        tx_pipe.push_back(1'b1);
        ll_pipe.push_back(1'b0);
      end
      m_txs = 1'b1; m_txprev = 1'b1; m_lls = 1'b0;
      m_armed = 1'b1; m_flag = 1'b0; m_stuck_cycles = 0;
    end else begin
      drv_now = !m_txs && m_armed && !shutdown_i;
      stuck   = drv_now && !m_lls;
      fire    = stuck && (m_stuck_cycles == LIMIT - 1);
      fall    = m_txprev && !m_txs;
      m_stuck_cycles = (stuck && !fire) ? m_stuck_cycles + 1 : 0;
      if (fall) begin
        m_armed = 1'b1; m_flag = 1'b0;
      end else if (fire) begin
        m_armed = 1'b0; m_flag = 1'b1;
      end
      m_txprev = m_txs;
      tx_pipe.push_back(tx_i);
      ll_pipe.push_back(line_low_i);
      void'(tx_pipe.pop_front());
      void'(ll_pipe.pop_front());
      m_txs = tx_pipe[0];
      m_lls = ll_pipe[0];
    end
    #1;
    if (rst_n && !done) begin
      chk("R1/R3/R5/R7 model drv_en", int'(drv_en_o),
          int'(!m_txs && m_armed && !shutdown_i));
      chk("R2 model rx", int'(rx_o), int'(!m_lls));
      chk("R6 model short_flag", int'(short_flag_o), int'(m_flag));
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] pat;
    int on_cnt;
    pat = 40'hA53C0F96E1;

    tick(4);
    // R8 reset state
    chk("R8 drv_en in reset", int'(drv_en_o), 0);
    chk("R8 rx in reset", int'(rx_o), 1);
    chk("R8 flag in reset", int'(short_flag_o), 0);
    rst_n = 1'b1;
    tick(2);

    // R1 latency and polarity
    tx_i = 1'b0;
    tick(1);
    chk("R1 drv_en before sync delay", int'(drv_en_o), 0);
    tick(1);
    chk("R1 drv_en after sync delay", int'(drv_en_o), 1);
    tick(4);
    chk("R2 rx low while bus pulled", int'(rx_o), 0);
    tx_i = 1'b1;
    tick(2);
    chk("R1 drv_en released", int'(drv_en_o), 0);
    tick(4);

    // R2 other node pulls bus, driver idle
    ext_low = 1'b1;
    tick(3);
    chk("R2 rx follows foreign low", int'(rx_o), 0);
    ext_low = 1'b0;
    tick(3);
    chk("R2 rx back high", int'(rx_o), 1);

    // R1 R2 data stream on healthy bus
    for (int b = 39; b >= 0; b--) begin
      tx_i = pat[b];
      tick(3);
    end
    tx_i = 1'b1;
    tick(6);
    chk("R6 no flag after healthy stream", int'(short_flag_o), 0);

    // R3 R5 R6 shorted bus
    bus_short = 1'b1;
    tx_i = 1'b0;
    on_cnt = 0;
    for (int c = 0; c < LIMIT + 20; c++) begin
      tick(1);
      if (drv_en_o) on_cnt++;
    end
    chk("R3 driven cycles against stuck bus", on_cnt, LIMIT);
    chk("R6 flag set after timeout", int'(short_flag_o), 1);
    chk("R5 held-low tx does not re-arm", int'(drv_en_o), 0);
    tx_i = 1'b1;
    tick(4);
    chk("R5 high tx does not re-arm", int'(drv_en_o), 0);
    chk("R6 flag held while tx high", int'(short_flag_o), 1);
    tx_i = 1'b0;
    tick(3);
    chk("R5 falling edge re-arms", int'(drv_en_o), 1);
    chk("R6 flag cleared on re-arm", int'(short_flag_o), 0);
    tick(LIMIT + 4);
    chk("R3 second timeout", int'(drv_en_o), 0);
    tx_i = 1'b1;
    tick(4);

    // R4 brief dip restarts the timer
    tx_i = 1'b0;
    tick(LIMIT - 4);
    ext_low = 1'b1;
    tick(1);
    ext_low = 1'b0;
    tick(8);
    chk("R4 dip restarted timer", int'(drv_en_o), 1);
    chk("R4 no flag yet", int'(short_flag_o), 0);
    tick(LIMIT + 4);
    chk("R4 timeout after restart", int'(drv_en_o), 0);
    chk("R6 flag after restarted timeout", int'(short_flag_o), 1);
    tx_i = 1'b1;
    tick(4);

    // R7 shutdown
    tx_i = 1'b0;
    tick(3);
    chk("R7 driving before shutdown", int'(drv_en_o), 1);
    shutdown_i = 1'b1;
    #1;
    chk("R7 shutdown kills driver at once", int'(drv_en_o), 0);
    tick(3 * LIMIT);
    chk("R7 driver off through shutdown", int'(drv_en_o), 0);
    chk("R7 no timeout during shutdown", int'(short_flag_o), 0);
    shutdown_i = 1'b0;
    #1;
    chk("R7 driver back after release", int'(drv_en_o), 1);
    tick(LIMIT + 4);
    chk("R3 timeout after shutdown release", int'(drv_en_o), 0);
    chk("R6 flag after release timeout", int'(short_flag_o), 1);
    tx_i = 1'b1;
    bus_short = 1'b0;
    tick(6);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule